// File: doc/BRIEF.md
# Min-Max Luma Edge Steepener

This block sharpens large luminance transitions in a video stream without a linear sharpening filter. Unsigned luma samples enter one per clock, qualified by a valid strobe, and move through a five-tap window. For the window around each centre sample the block finds the local minimum and maximum. It then replaces the centre sample with one of those two extremes. The choice follows the sign of a wide second-derivative contour: on the lower half of an edge the output snaps to the minimum, and on the upper half it snaps to the maximum, so a soft ramp becomes a steep step.

A six-bit line-width code adds a signed bias to the contour before the sign test. This moves the switching point along an edge and so widens or narrows bright features. Small excursions, where the window's spread is below a threshold, are passed through untouched. The spread (max minus min) is also output as an envelope for a later peaking stage. The contour and the delay-matched centre sample are output for downstream blending as well. All outputs are registered and updated together.

Top module: `mmx_step_enhancer`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` goes low and `step_y`, `envelope`, `contour` and `orig_y` go to zero after that edge.
- R2: A sample enters the window only on a clock edge where `in_valid` is high. Cycles with `in_valid` low do not move the window. No result is produced until five samples have been accepted since reset.
- R3: The edge that accepts the fifth or any later sample produces `out_valid` high exactly one clock later, as a single-cycle pulse. While `out_valid` is low, all data outputs hold their values.
- R4: `envelope` equals the maximum minus the minimum of the five window samples (newest, the three between, oldest).
- R5: `contour` is the signed value 2*centre - newest - oldest, where centre is the sample accepted two samples before the newest.
- R6: `orig_y` equals the centre sample of the window that produced the result.
- R7: When `envelope` is at least STEP_THR, a decision value is formed as contour + (code - 32) * 2^LW_SHIFT. Here code is `lw_code` taken as an unsigned number, so code 32 adds nothing. `step_y` is the window maximum when the decision is zero or positive, and the window minimum when it is negative.
- R8: When `envelope` is below STEP_THR, `step_y` equals `orig_y`.
- R9: `lw_code` is captured on the same edge as the sample. A result uses the code present with its newest sample, and code changes between accepted samples have no effect on that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_y` and `lw_code` |
| in_y | input | W | Unsigned luma sample |
| lw_code | input | LW_BITS | Line-width bias code, 32 = neutral |
| out_valid | output | 1 | One-cycle pulse when new results are present |
| step_y | output | W | Edge-steepened luma |
| envelope | output | W | Window max minus min |
| contour | output | W+2 | Signed second-derivative contour |
| orig_y | output | W | Delay-matched centre sample |

## Verification
The bench uses W=8, STEP_THR=24 and LW_SHIFT=2. With these values the line-width bias spans -128 to +124. That is a useful fraction of the ±510 contour range, so random codes really flip the min/max choice on edges. A threshold of 24 means that narrow-band random runs land below it while full-range steps land well above it, so both the pass-through branch and the steepening branch are exercised often. Gaps in `in_valid` test the window hold and the output hold between results.

// File: rtl/mmx_pkg.sv
package mmx_pkg;
  // neutral value of the line-width code for a given code width
  function automatic int lw_neutral(input int lw_bits);
    return 1 << (lw_bits - 1);
  endfunction
endpackage

// File: rtl/mmx_tapline.sv
module mmx_tapline #(
  parameter int W    = 8,
  parameter int TAPS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [W-1:0]      din,
  output logic [TAPS*W-1:0] taps
);
  // tap 0 holds the newest sample, tap TAPS-1 the oldest
  logic [W-1:0] stage [TAPS];

  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
      always_ff @(posedge clk) begin
        if (rst)
          stage[i] <= '0;
        else if (shift_en)
          stage[i] <= (i == 0) ? din : stage[(i == 0) ? 0 : i - 1];
      end
      assign taps[i*W +: W] = stage[i];
    end
  endgenerate
endmodule

// File: rtl/mmx_extrema.sv
module mmx_extrema #(
  parameter int W    = 8,
  parameter int TAPS = 5
) (
  input  logic [TAPS*W-1:0] taps,
  output logic [W-1:0]      lo,
  output logic [W-1:0]      hi
);
  always_comb begin
    lo = taps[0 +: W];
    hi = taps[0 +: W];
    for (int i = 1; i < TAPS; i++) begin
      if (taps[i*W +: W] < lo) lo = taps[i*W +: W];
      if (taps[i*W +: W] > hi) hi = taps[i*W +: W];
    end
  end
endmodule

// File: rtl/mmx_contour.sv
module mmx_contour #(
  parameter int W  = 8,
  localparam int CW = W + 2
) (
  input  logic [W-1:0]          newest,
  input  logic [W-1:0]          centre,
  input  logic [W-1:0]          oldest,
  output logic signed [CW-1:0]  con
);
  logic signed [CW-1:0] twice_c, a_n, a_o;
  always_comb begin
    twice_c = {1'b0, centre, 1'b0};
    a_n     = {2'b00, newest};
    a_o     = {2'b00, oldest};
    con     = twice_c - a_n - a_o;
  end
endmodule

// File: rtl/mmx_step_enhancer.sv
module mmx_step_enhancer #(
  parameter int W        = 8,
  parameter int LW_BITS  = 6,
  parameter int LW_SHIFT = 2,
  parameter int STEP_THR = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [W-1:0]        in_y,
  input  logic [LW_BITS-1:0]  lw_code,
  output logic                out_valid,
  output logic [W-1:0]        step_y,
  output logic [W-1:0]        envelope,
  output logic signed [W+1:0] contour,
  output logic [W-1:0]        orig_y
);
  import mmx_pkg::*;

  localparam int TAPS   = 5;
  localparam int CENTER = TAPS / 2;
  localparam int CW     = W + 2;
  localparam int OW     = LW_BITS + LW_SHIFT + 1;
  localparam int DW     = ((CW > OW) ? CW : OW) + 1;
  localparam int FILLW  = $clog2(TAPS + 1);
  localparam logic signed [DW-1:0] LW_ZERO = DW'(lw_neutral(LW_BITS));

  // window stage
  logic [TAPS*W-1:0]   taps;
  logic [FILLW-1:0]    fill_q;
  logic                calc_q;
  logic [LW_BITS-1:0]  lw_q;

  mmx_tapline #(.W(W), .TAPS(TAPS)) u_taps (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_y), .taps(taps)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      calc_q <= 1'b0;
      lw_q   <= '0;
    end else begin
      calc_q <= in_valid && (fill_q >= FILLW'(TAPS - 1));
      if (in_valid) begin
        lw_q <= lw_code;
        if (fill_q < FILLW'(TAPS)) fill_q <= fill_q + 1'b1;
      end
    end
  end

  // arithmetic on the current window
  logic [W-1:0]          w_lo, w_hi, w_mid, w_env;
  logic signed [CW-1:0]  w_con;

  assign w_mid = taps[CENTER*W +: W];
  assign w_env = w_hi - w_lo;

  mmx_extrema #(.W(W), .TAPS(TAPS)) u_ext (
    .taps(taps), .lo(w_lo), .hi(w_hi)
  );

  mmx_contour #(.W(W)) u_con (
    .newest(taps[0 +: W]),
    .centre(w_mid),
    .oldest(taps[(TAPS-1)*W +: W]),
    .con(w_con)
  );

  logic signed [DW-1:0] lw_ext, lw_off, con_ext, decision;
  logic [W-1:0]         pick;

  always_comb begin
    lw_ext   = {{(DW-LW_BITS){1'b0}}, lw_q};
    lw_off   = (lw_ext - LW_ZERO) <<< LW_SHIFT;
    con_ext  = {{(DW-CW){w_con[CW-1]}}, w_con};
    decision = con_ext + lw_off;
    if (w_env < W'(STEP_THR))
      pick = w_mid;
    else if (decision[DW-1])
      pick = w_lo;
    else
      pick = w_hi;
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      step_y    <= '0;
      envelope  <= '0;
      contour   <= '0;
      orig_y    <= '0;
    end else begin
      out_valid <= calc_q;
      if (calc_q) begin
        step_y   <= pick;
        envelope <= w_env;
        contour  <= w_con;
        orig_y   <= w_mid;
      end
    end
  end
endmodule

// File: rtl/mmx_step_enhancer_chk.sv
module mmx_step_enhancer_chk #(
  parameter int W        = 8,
  parameter int STEP_THR = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] step_y,
  input logic [W-1:0] envelope,
  input logic [W-1:0] orig_y
);
  int diff;
  always_comb diff = (step_y > orig_y) ? int'(step_y - orig_y) : int'(orig_y - step_y);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && step_y == '0 && envelope == '0 && orig_y == '0));

  // R3
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(step_y) && $stable(envelope) && $stable(orig_y)));

  // R3
  p_follows_input_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R8
  p_pass_small_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && envelope < W'(STEP_THR)) |-> step_y == orig_y);

  // R7
  p_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> diff <= int'(envelope));
endmodule

bind mmx_step_enhancer mmx_step_enhancer_chk #(.W(W), .STEP_THR(STEP_THR)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .step_y(step_y), .envelope(envelope), .orig_y(orig_y)
);

// File: tb/mmx_step_enhancer_test.sv
module mmx_step_enhancer_test;
  localparam int W = 8, LB = 6, LS = 2, THR = 24;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [W-1:0] in_y = '0;
  logic [LB-1:0] lw_code = 6'd32;
  logic out_valid;
  logic [W-1:0] step_y, envelope, orig_y;
  logic signed [W+1:0] contour;

  always #2.5 clk = ~clk;

  mmx_step_enhancer #(.W(W), .LW_BITS(LB), .LW_SHIFT(LS), .STEP_THR(THR)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_y(in_y), .lw_code(lw_code),
    .out_valid(out_valid), .step_y(step_y), .envelope(envelope),
    .contour(contour), .orig_y(orig_y)
  );

  typedef struct { bit v; int stp, env, con, org; } exp_t;
  exp_t e1, e2, held;
  int win [5];
  int fill = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(exp_t e);
    chk("R3 out_valid", int'(out_valid), int'(e.v));
    chk("R4 envelope", int'(envelope), e.env);
    chk("R5 contour", int'(contour), e.con);
    chk("R6 orig_y", int'(orig_y), e.org);
    chk("R7/R8/R9 step_y", int'(step_y), e.stp);
  endtask

  task automatic step(bit v, int s, int lw);
    exp_t ne;
    @(negedge clk);
    check_out(e2);
    in_valid = v; in_y = W'(s); lw_code = LB'(lw);
    ne = held; ne.v = 0;
    if (v) begin
      for (int i = 4; i > 0; i--) win[i] = win[i-1];
      win[0] = s;
      if (fill < 5) fill++;
      if (fill == 5) begin
        int lo, hi, d;
        lo = win[0]; hi = win[0];
        for (int i = 1; i < 5; i++) begin
          if (win[i] < lo) lo = win[i];
          if (win[i] > hi) hi = win[i];
        end
        ne.v = 1;
        ne.env = hi - lo;
        ne.con = 2*win[2] - win[0] - win[4];
        ne.org = win[2];
        d = ne.con + (lw - 32) * (1 << LS);
        if (ne.env < THR) ne.stp = win[2];
        else ne.stp = (d >= 0) ? hi : lo;
        held = ne;
      end
    end
    e2 = e1; e1 = ne;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    exp_t z;
    z = '{0, 0, 0, 0, 0};
    e1 = z; e2 = z; held = z;
    for (int i = 0; i < 5; i++) win[i] = 0;
    void'($urandom(32'd1977));
    in_valid = 1; in_y = 8'd200;       // driven during reset: must be ignored
    repeat (3) @(negedge clk);
    // R1: reset state
    check_out(z);
    rst = 0; in_valid = 0;
    // R2: four samples, no output; gaps do not shift
    step(1, 10, 32); step(0, 99, 32); step(1, 10, 32); step(1, 10, 32);
    step(0, 77, 32); step(1, 10, 32);
    // R2/R3: fifth sample gives first result; ramp up edge, neutral code
    step(1, 250, 32); step(1, 250, 32); step(1, 250, 32);
    step(1, 250, 32); step(1, 250, 32);
    // R7: strong bias toward min, then toward max, across an edge
    step(1, 0, 0); step(1, 60, 0); step(1, 130, 0); step(1, 200, 0); step(1, 255, 0);
    step(1, 0, 63); step(1, 60, 63); step(1, 130, 63); step(1, 200, 63); step(1, 255, 63);
    // R9: code changes while invalid are ignored
    step(1, 0, 32); step(0, 0, 0); step(1, 100, 32); step(0, 0, 63); step(1, 200, 32);
    // R8: small ripple passes through
    step(1, 120, 5); step(1, 130, 60); step(1, 125, 0); step(1, 128, 63); step(1, 122, 32);
    // random mix
    for (int n = 0; n < 6000; n++) begin
      int s, mode;
      mode = int'($urandom % 4);
      if (mode == 0) s = int'($urandom % 256);
      else if (mode == 1) s = 100 + int'($urandom % 16);
      else s = ($urandom % 2) ? 255 - int'($urandom % 8) : int'($urandom % 8);
      step(($urandom % 4) != 0, s, int'($urandom % 64));
    end
    step(0, 0, 32); step(0, 0, 32); step(0, 0, 32);
    done = 1;
    finish_run();
  end
endmodule